// File: doc/BRIEF.md
# Address Window Decoder

This block sorts every 32-bit CPU address into one of six programmable address windows. Each window holds a base, a size mask, a target ID, an attribute byte and an enable bit. A lookup is purely combinational. It reports a miss when no window claims the address. Otherwise it reports the winning window index and that window's target and attribute.

Window size is not a byte count. It is a 16-bit mask that counts 64 KB units: the mask is a run of ones that starts at bit 0, followed only by zeros. An all-zero mask is the smallest window, 64 KB. 0x00FF covers 16 MB and 0x07FF covers 128 MB.

A single register write port loads one window field per clock. A mask that is not a contiguous run of ones from the least significant bit disables its window and raises a sticky error flag.

Top module: `addr_window_decoder`

## Requirements
- R1: Once reset is released, every window is disabled, `lk_miss` is 1 and `size_err` is 0.
- R2: An enabled window with a legal mask hits when `lk_addr[31:16]` and the stored base agree on every bit where the mask is 0. Base bits under mask ones are ignored.
- R3: A zero mask gives a 64 KB window. The last byte `base+0xFFFF` hits and `base+0x10000` misses.
- R4: Mask 0x00FF gives a 16 MB window and mask 0x07FF a 128 MB window, with both edges exact.
- R5: When several windows hit, the lowest-numbered one is reported together with its own target and attribute.
- R6: When no window hits, `lk_miss` is 1 and `lk_win`, `lk_target` and `lk_attr` are all 0.
- R7: A window with its enable bit at 0 never hits.
- R8: Writing a non-contiguous mask (mask & (mask+1) nonzero) sets `size_err` from the next clock edge until reset, and that window misses. Writing a legal mask later restores the window but leaves `size_err` set.
- R9: Write fields are selected by `wr_field`. Code 0 sets the base from `wr_data[31:16]`. Code 1 sets the mask from `wr_data[15:0]`. Code 2 sets the target from `wr_data[3:0]` and the attribute from `wr_data[15:8]`. Code 3 sets the enable from `wr_data[0]`. Writes to window indices 6 and 7 are ignored.
- R10: Lookup results follow `lk_addr` in the same cycle. A register write takes effect at the clock edge that samples it, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 3 | Window index for the write |
| wr_field | input | 2 | Field select: 0 base, 1 mask, 2 target/attribute, 3 enable |
| wr_data | input | 32 | Write data |
| lk_addr | input | 32 | Address to look up |
| lk_miss | output | 1 | No window matched |
| lk_win | output | 3 | Index of the winning window |
| lk_target | output | 4 | Target ID of the winning window |
| lk_attr | output | 8 | Attribute of the winning window |
| size_err | output | 1 | Sticky flag for an illegal mask write |

## Verification
The lookup outputs are due in the same cycle as the address, with no register on the path. The bench therefore changes `lk_addr` at the falling edge and samples one nanosecond later, before the next rising edge. A write changes the lookup only after the rising edge that captures it, and the error flag also appears after that edge. Write tests sample the lookup once before that edge to see the old result, and once after it to see the new one.

// File: rtl/awd_pkg.sv
package awd_pkg;
  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_SIZE  = 2'd1,
    FLD_ROUTE = 2'd2,
    FLD_CTRL  = 2'd3
  } awd_field_e;

  localparam int ATTR_LSB = 8;

  function automatic logic mask_is_run(input logic [15:0] m);
    return ((m & (m + 16'd1)) == 16'd0);
  endfunction
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int ADDR_W  = 32,
  parameter int PAGE_W  = 16,
  parameter int TGT_W   = 4,
  parameter int ATTR_W  = 8,
  localparam int MASK_W = ADDR_W - PAGE_W,
  localparam int WIN_W  = $clog2(NUM_WIN + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [WIN_W-1:0]                wr_win,
  input  logic [1:0]                      wr_field,
  input  logic [ADDR_W-1:0]               wr_data,
  output logic [NUM_WIN-1:0][MASK_W-1:0]  base_q,
  output logic [NUM_WIN-1:0][MASK_W-1:0]  mask_q,
  output logic [NUM_WIN-1:0][TGT_W-1:0]   tgt_q,
  output logic [NUM_WIN-1:0][ATTR_W-1:0]  attr_q,
  output logic [NUM_WIN-1:0]              en_q,
  output logic [NUM_WIN-1:0]              bad_q,
  output logic                            err_q
);
  logic [MASK_W-1:0] wr_mask;
  logic              wr_mask_ok;
  logic              err_n;
  logic              in_range;

  assign wr_mask    = wr_data[MASK_W-1:0];
  assign wr_mask_ok = mask_is_run(wr_mask);
  assign in_range   = (wr_win < WIN_W'(NUM_WIN));

  always_comb begin
    err_n = err_q;
    if (wr_en && in_range && (awd_field_e'(wr_field) == FLD_SIZE) && !wr_mask_ok) begin
      err_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_n;
    end
  end

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    logic              sel;
    logic [MASK_W-1:0] base_n;
    logic [MASK_W-1:0] mask_n;
    logic [TGT_W-1:0]  tgt_n;
    logic [ATTR_W-1:0] attr_n;
    logic              en_n;
    logic              bad_n;
    logic              ld;

    assign sel = wr_en && (wr_win == WIN_W'(gi));

    always_comb begin
      base_n = base_q[gi];
      mask_n = mask_q[gi];
      tgt_n  = tgt_q[gi];
      attr_n = attr_q[gi];
      en_n   = en_q[gi];
      bad_n  = bad_q[gi];
      ld     = 1'b0;
      if (sel) begin
        ld = 1'b1;
        unique case (awd_field_e'(wr_field))
          FLD_BASE:  base_n = wr_data[ADDR_W-1 -: MASK_W];
          FLD_SIZE: begin
            mask_n = wr_mask;
            bad_n  = !wr_mask_ok;
          end
          FLD_ROUTE: begin
            tgt_n  = wr_data[TGT_W-1:0];
            attr_n = wr_data[ATTR_LSB +: ATTR_W];
          end
          FLD_CTRL:  en_n = wr_data[0];
          default:   ld = 1'b0;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[gi] <= '0;
        mask_q[gi] <= '0;
        tgt_q[gi]  <= '0;
        attr_q[gi] <= '0;
        en_q[gi]   <= 1'b0;
        bad_q[gi]  <= 1'b0;
      end else if (ld) begin
        base_q[gi] <= base_n;
        mask_q[gi] <= mask_n;
        tgt_q[gi]  <= tgt_n;
        attr_q[gi] <= attr_n;
        en_q[gi]   <= en_n;
        bad_q[gi]  <= bad_n;
      end
    end
  end
endmodule

// File: rtl/awd_match.sv
module awd_match #(
  parameter int NUM_WIN = 6,
  parameter int MASK_W  = 16
) (
  input  logic [MASK_W-1:0]              page,
  input  logic [NUM_WIN-1:0][MASK_W-1:0] base_q,
  input  logic [NUM_WIN-1:0][MASK_W-1:0] mask_q,
  input  logic [NUM_WIN-1:0]             live,
  output logic [NUM_WIN-1:0]             hit
);
  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_cmp
    logic [MASK_W-1:0] care;
    assign care    = ~mask_q[gi];
    assign hit[gi] = live[gi] && ((page & care) == (base_q[gi] & care));
  end
endmodule

// File: rtl/awd_select.sv
module awd_select #(
  parameter int NUM_WIN = 6,
  parameter int TGT_W   = 4,
  parameter int ATTR_W  = 8,
  localparam int WIN_W  = $clog2(NUM_WIN + 1)
) (
  input  logic [NUM_WIN-1:0]             hit,
  input  logic [NUM_WIN-1:0][TGT_W-1:0]  tgt_q,
  input  logic [NUM_WIN-1:0][ATTR_W-1:0] attr_q,
  output logic                           miss,
  output logic [WIN_W-1:0]               win,
  output logic [TGT_W-1:0]               tgt,
  output logic [ATTR_W-1:0]              attr
);
  always_comb begin
    miss = 1'b1;
    win  = '0;
    tgt  = '0;
    attr = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        miss = 1'b0;
        win  = WIN_W'(i);
        tgt  = tgt_q[i];
        attr = attr_q[i];
      end
    end
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NUM_WIN = 6,
  parameter int ADDR_W  = 32,
  parameter int PAGE_W  = 16,
  parameter int TGT_W   = 4,
  parameter int ATTR_W  = 8,
  localparam int MASK_W = ADDR_W - PAGE_W,
  localparam int WIN_W  = $clog2(NUM_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIN_W-1:0]  wr_win,
  input  logic [1:0]        wr_field,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_miss,
  output logic [WIN_W-1:0]  lk_win,
  output logic [TGT_W-1:0]  lk_target,
  output logic [ATTR_W-1:0] lk_attr,
  output logic              size_err
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_WIN-1:0][MASK_W-1:0] base_q;
  logic [NUM_WIN-1:0][MASK_W-1:0] mask_q;
  logic [NUM_WIN-1:0][TGT_W-1:0]  tgt_q;
  logic [NUM_WIN-1:0][ATTR_W-1:0] attr_q;
  logic [NUM_WIN-1:0]             en_q;
  logic [NUM_WIN-1:0]             bad_q;
  logic [NUM_WIN-1:0]             win_live;
  logic [NUM_WIN-1:0]             hit;
  logic [PAGE_W-1:0]              unused_offset;

  assign unused_offset = lk_addr[PAGE_W-1:0];

  awd_regfile #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .TGT_W(TGT_W), .ATTR_W(ATTR_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_win(wr_win),
    .wr_field(wr_field), .wr_data(wr_data),
    .base_q(base_q), .mask_q(mask_q), .tgt_q(tgt_q), .attr_q(attr_q),
    .en_q(en_q), .bad_q(bad_q), .err_q(size_err)
  );

  assign win_live = en_q & ~bad_q;

  awd_match #(.NUM_WIN(NUM_WIN), .MASK_W(MASK_W)) match_i (
    .page(lk_addr[ADDR_W-1 -: MASK_W]), .base_q(base_q), .mask_q(mask_q),
    .live(win_live), .hit(hit)
  );

  awd_select #(.NUM_WIN(NUM_WIN), .TGT_W(TGT_W), .ATTR_W(ATTR_W)) sel_i (
    .hit(hit), .tgt_q(tgt_q), .attr_q(attr_q),
    .miss(lk_miss), .win(lk_win), .tgt(lk_target), .attr(lk_attr)
  );
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int NUM_WIN = 6,
  parameter int TGT_W   = 4,
  parameter int ATTR_W  = 8,
  localparam int WIN_W  = $clog2(NUM_WIN + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               lk_miss,
  input logic [WIN_W-1:0]   lk_win,
  input logic [TGT_W-1:0]   lk_target,
  input logic [ATTR_W-1:0]  lk_attr,
  input logic               size_err,
  input logic [NUM_WIN-1:0] win_live
);
  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_win == '0 && lk_target == '0 && lk_attr == '0));

  // R9
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_miss |-> (lk_win < WIN_W'(NUM_WIN)));

  // R7
  live_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_miss |-> (|(win_live & (NUM_WIN'(1) << lk_win))));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |=> size_err);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(size_err) |-> $past(wr_en));

  // R1
  none_live_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_live == '0) |-> lk_miss);
endmodule

bind addr_window_decoder awd_checker #(
  .NUM_WIN(NUM_WIN), .TGT_W(TGT_W), .ATTR_W(ATTR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lk_miss(lk_miss),
  .lk_win(lk_win), .lk_target(lk_target), .lk_attr(lk_attr),
  .size_err(size_err), .win_live(win_live)
);

// File: tb/addr_window_decoder_tb_top.sv
module addr_window_decoder_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_win;
  logic [1:0]  wr_field;
  logic [31:0] wr_data;
  logic [31:0] lk_addr;
  logic        lk_miss;
  logic [2:0]  lk_win;
  logic [3:0]  lk_target;
  logic [7:0]  lk_attr;
  logic        size_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  addr_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win),
    .wr_field(wr_field), .wr_data(wr_data), .lk_addr(lk_addr),
    .lk_miss(lk_miss), .lk_win(lk_win), .lk_target(lk_target),
    .lk_attr(lk_attr), .size_err(size_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {addr[47:16], miss[15], win[14:12], target[11:8], attr[7:0]}
  localparam int NV = 12;
  localparam logic [47:0] VEC [NV] = '{
    {32'h9000_0000, 1'b0, 3'd0, 4'h1, 8'hA0},  // R4 128MB low edge
    {32'h97FF_FFFF, 1'b0, 3'd0, 4'h1, 8'hA0},  // R4 128MB high edge
    {32'h9800_0000, 1'b1, 3'd0, 4'h0, 8'h00},  // R4 just past 128MB
    {32'h9400_1234, 1'b0, 3'd0, 4'h1, 8'hA0},  // R5 overlap 0 and 1
    {32'hF400_FFFF, 1'b0, 3'd2, 4'h3, 8'hC2},  // R3 last byte of 64KB
    {32'hF401_0000, 1'b1, 3'd0, 4'h0, 8'h00},  // R3 past 64KB
    {32'hA0FF_FFFF, 1'b0, 3'd3, 4'h4, 8'hD3},  // R4 16MB high edge
    {32'hA100_0000, 1'b1, 3'd0, 4'h0, 8'h00},  // R4 past 16MB
    {32'hB000_0000, 1'b1, 3'd0, 4'h0, 8'h00},  // R7 disabled window
    {32'hC003_FFFF, 1'b0, 3'd5, 4'h6, 8'hF5},  // R2 base bits under mask ignored
    {32'hC004_0000, 1'b1, 3'd0, 4'h0, 8'h00},  // R2 outside
    {32'h0000_0000, 1'b1, 3'd0, 4'h0, 8'h00}   // R6 miss
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic look(input string req, input logic [31:0] a, input logic m,
                      input logic [2:0] w, input logic [3:0] t, input logic [7:0] at);
    lk_addr = a;
    #1;
    check(req, {16'd0, lk_miss, lk_win, lk_target, lk_attr},
               {16'd0, m, w, t, at});
  endtask

  task automatic wr(input logic [2:0] w, input logic [1:0] f, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_win = w; wr_field = f; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup_win(input logic [2:0] w, input logic [31:0] base, input logic [15:0] m,
                           input logic [3:0] t, input logic [7:0] at, input logic en);
    wr(w, 2'd0, base);
    wr(w, 2'd1, {16'd0, m});
    wr(w, 2'd2, {16'd0, at, 4'd0, t});
    wr(w, 2'd3, {31'd0, en});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_win = '0; wr_field = '0; wr_data = '0; lk_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    look("R1", 32'h0000_0000, 1'b1, 3'd0, 4'h0, 8'h00);
    check("R1", {31'd0, size_err}, 32'd0);

    setup_win(3'd0, 32'h9000_0000, 16'h07FF, 4'h1, 8'hA0, 1'b1);
    setup_win(3'd1, 32'h9400_0000, 16'h00FF, 4'h2, 8'hB1, 1'b1);
    setup_win(3'd2, 32'hF400_0000, 16'h0000, 4'h3, 8'hC2, 1'b1);
    setup_win(3'd3, 32'hA000_0000, 16'h00FF, 4'h4, 8'hD3, 1'b1);
    setup_win(3'd4, 32'hB000_0000, 16'h000F, 4'h5, 8'hE4, 1'b0);
    setup_win(3'd5, 32'hC002_0000, 16'h0003, 4'h6, 8'hF5, 1'b1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      look($sformatf("table[%0d] R2/R3/R4/R5/R6/R7", i), VEC[i][47:16], VEC[i][15],
           VEC[i][14:12], VEC[i][11:8], VEC[i][7:0]);
    end

    // R10 / R5: disable window 0; old result before the edge, new after
    @(negedge clk);
    wr_en = 1'b1; wr_win = 3'd0; wr_field = 2'd3; wr_data = 32'd0;
    look("R10 before edge", 32'h9400_1234, 1'b0, 3'd0, 4'h1, 8'hA0);
    @(negedge clk);
    wr_en = 1'b0;
    look("R5 R7 after disable", 32'h9400_1234, 1'b0, 3'd1, 4'h2, 8'hB1);
    look("R7 disabled 0", 32'h9000_0000, 1'b1, 3'd0, 4'h0, 8'h00);

    // R8 illegal mask
    wr(3'd5, 2'd1, 32'h0000_0005);
    look("R8 window off", 32'hC001_0000, 1'b1, 3'd0, 4'h0, 8'h00);
    check("R8 err set", {31'd0, size_err}, 32'd1);
    wr(3'd5, 2'd1, 32'h0000_0003);
    look("R8 restored", 32'hC001_0000, 1'b0, 3'd5, 4'h6, 8'hF5);
    check("R8 err sticky", {31'd0, size_err}, 32'd1);

    // R9 out-of-range writes ignored
    wr(3'd6, 2'd0, 32'h0000_0000);
    wr(3'd6, 2'd3, 32'h0000_0001);
    wr(3'd7, 2'd2, 32'h0000_FF0F);
    look("R9 oob ignored", 32'h0000_0000, 1'b1, 3'd0, 4'h0, 8'h00);
    look("R9 win2 intact", 32'hF400_0000, 1'b0, 3'd2, 4'h3, 8'hC2);

    // R1 reset again clears flag and windows
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    look("R1 after reset", 32'hF400_0000, 1'b1, 3'd0, 4'h0, 8'h00);
    check("R1 err cleared", {31'd0, size_err}, 32'd0);

    done = 1;
    finish_run();
  end
endmodule